// File: doc/BRIEF.md
# Memory-Mapped Event Timer with Prescaler

This block is an up-counting timer peripheral that software programs over a simple 32-bit register bus and that signals through one level interrupt line. A prescaler divides the input clock by a programmable ratio. The main counter then steps from zero up to a reload value. When it reaches that value, the block raises an update event, sets a status flag and returns the counter to zero.

The counter can run periodically, or in one-pulse mode, where it stops by itself after the first event. Writes to the reload value can be buffered until the next update event. Writes to the prescaler ratio are always buffered that way. Software can force an update event to load the buffered values and restart the count.

The counter width is a parameter of 16 or 32 bits. Software finds the width by writing all ones to the reload register and reading the value back.

Top module: `evt_tmr`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: The reload register (offset 0x2C) keeps only the low CNT_W bits. Writing 0xFFFFFFFF reads back as 2^CNT_W-1, which is 0x0000FFFF at the default width of 16.
- R3: The prescaler register (offset 0x28, bits 15:0) holds N-1, and the counter advances once every N clocks. A newly written ratio is held back until the next update event.
- R4: The control register is at offset 0x00. With bit 0 (run) set and bit 3 (one-pulse) clear, an update event fires when the counter equals the reload value at the end of a prescaler period. The counter then wraps to zero and keeps counting, so events come every (reload+1)*(prescaler+1) clocks.
- R5: With bit 3 of the control register set, the update event also clears bit 0 of the control register, and the counter stops after one event.
- R6: With bit 7 of the control register set, a reload write only updates a buffered copy, which becomes active at the next update event. With bit 7 clear, the write is active in the next cycle.
- R7: Writing 1 to bit 0 of the event-generation register (offset 0x14) forces an update event. This zeroes the prescaler counter and the main counter, loads the buffered prescaler and reload values, and sets the update flag.
- R8: Bit 0 of the status register (offset 0x10) is the update flag. Writing 0 clears it and writing 1 leaves it unchanged. An update event in the same cycle as a clear wins.
- R9: `irq` is high exactly while the update flag and bit 0 of the interrupt-enable register (offset 0x0C) are both set.
- R10: Undecoded offsets, the event-generation register and unlisted control bits read as zero and ignore writes. Writing 0xFFFFFFFF to control reads back 0x00000089.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Update interrupt, level |

## Verification
The timer is run with a prescaler of zero and with a prescaler of two, each against a short reload value. The measured event spacing shows whether the division ratio is applied as N-1 and whether the reload compare is inclusive.

One-pulse runs are set against periodic runs, which shows whether run clears only in one-pulse mode. Buffered and unbuffered reload writes made while the counter is running show when a new reload value becomes active. A reference model stepped in the bench checks the interrupt line and the read data on every clock.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EVGEN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PSC    = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h2C;

    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_ONCE_BIT = 3;
    localparam int CTL_BUF_BIT  = 7;

    typedef struct packed {
        logic buf_en;
        logic once;
        logic run;
    } ctl_t;

    typedef struct packed {
        logic ctl_wr;
        logic ien_wr;
        logic stat_wr;
        logic force_upd;
        logic psc_wr;
        logic rld_wr;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic we,
                                          input logic [ADDR_W-1:0] a,
                                          input logic bit0);
        wr_dec_t d;
        d.ctl_wr    = we && (a == OFS_CTRL);
        d.ien_wr    = we && (a == OFS_IEN);
        d.stat_wr   = we && (a == OFS_STAT);
        d.force_upd = we && (a == OFS_EVGEN) && bit0;
        d.psc_wr    = we && (a == OFS_PSC);
        d.rld_wr    = we && (a == OFS_RELOAD);
        return d;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctl(input ctl_t c);
        logic [BUS_W-1:0] v;
        v = '0;
        v[CTL_RUN_BIT]  = c.run;
        v[CTL_ONCE_BIT] = c.once;
        v[CTL_BUF_BIT]  = c.buf_en;
        return v;
    endfunction

endpackage

// File: rtl/evt_tmr_ctrl.sv
module evt_tmr_ctrl
    import evt_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_dec_t          dec,
    input  logic [BUS_W-1:0] wdata,
    input  logic             upd_evt,
    output ctl_t             ctl,
    output logic             ien,
    output logic             flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (dec.ctl_wr) begin
            ctl.run    <= wdata[CTL_RUN_BIT];
            ctl.once   <= wdata[CTL_ONCE_BIT];
            ctl.buf_en <= wdata[CTL_BUF_BIT];
        end else if (upd_evt && ctl.once) begin
            ctl.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien <= 1'b0;
        end else if (dec.ien_wr) begin
            ien <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (upd_evt) begin
            flag <= 1'b1;
        end else if (dec.stat_wr) begin
            flag <= flag & wdata[0];
        end
    end

    AST_ONEPULSE_STOP: assert property (@(posedge clk) disable iff (rst)
        (ctl.once && upd_evt && !dec.ctl_wr) |=> !ctl.run) else $error("one-pulse did not stop"); // R5

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(upd_evt)) else $error("flag set without update"); // R8

endmodule

// File: rtl/evt_tmr_shadow.sv
module evt_tmr_shadow
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_dec_t          dec,
    input  logic [BUS_W-1:0] wdata,
    input  logic             buf_en,
    input  logic             upd_evt,
    output logic [PSC_W-1:0] psc_reg,
    output logic [PSC_W-1:0] psc_act,
    output logic [CNT_W-1:0] rld_reg,
    output logic [CNT_W-1:0] rld_act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_reg <= '0;
        end else if (dec.psc_wr) begin
            psc_reg <= wdata[PSC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_act <= '0;
        end else if (upd_evt) begin
            psc_act <= psc_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_reg <= '0;
        end else if (dec.rld_wr) begin
            rld_reg <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_act <= '0;
        end else if (dec.rld_wr && !buf_en) begin
            rld_act <= wdata[CNT_W-1:0];
        end else if (upd_evt && buf_en) begin
            rld_act <= rld_reg;
        end
    end

    AST_RELOAD_BUFFERED: assert property (@(posedge clk) disable iff (rst)
        (buf_en && !upd_evt) |=> $stable(rld_act)) else $error("buffered reload leaked"); // R6

    AST_PSC_BUFFERED: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> $stable(psc_act)) else $error("prescaler changed outside update"); // R3

endmodule

// File: rtl/evt_tmr_count.sv
module evt_tmr_count #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             force_upd,
    input  logic [PSC_W-1:0] psc_act,
    input  logic [CNT_W-1:0] rld_act,
    output logic             ovf_evt
);

    logic [PSC_W-1:0] pcnt;
    logic [CNT_W-1:0] cnt;
    logic             pre_end;
    logic             at_top;

    assign pre_end = (pcnt == psc_act);
    assign at_top  = (cnt == rld_act);
    assign ovf_evt = run && pre_end && at_top;

    always_ff @(posedge clk) begin
        if (rst || force_upd) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= pre_end ? '0 : pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || force_upd) begin
            cnt <= '0;
        end else if (run && pre_end) begin
            cnt <= at_top ? '0 : cnt + 1'b1;
        end
    end

    AST_UPDATE_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt || force_upd) |=> (cnt == '0)) else $error("counter not zero after update"); // R7

    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !pre_end && !force_upd) |=> $stable(cnt)) else $error("counter moved mid-prescale"); // R3

endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int RLD_PAD = BUS_W - CNT_W;
    localparam int PSC_PAD = BUS_W - PSC_W;

    wr_dec_t          dec;
    ctl_t             ctl;
    logic             ien;
    logic             flag;
    logic             ovf_evt;
    logic             upd_evt;
    logic [PSC_W-1:0] psc_reg;
    logic [PSC_W-1:0] psc_act;
    logic [CNT_W-1:0] rld_reg;
    logic [CNT_W-1:0] rld_act;
    logic [BUS_W-1:0] rld_view;
    logic [BUS_W-1:0] psc_view;

    assign dec     = decode_wr(bus_we, bus_addr, bus_wdata[0]);
    assign upd_evt = ovf_evt || dec.force_upd;

    evt_tmr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .wdata   (bus_wdata),
        .upd_evt (upd_evt),
        .ctl     (ctl),
        .ien     (ien),
        .flag    (flag)
    );

    evt_tmr_shadow #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .wdata   (bus_wdata),
        .buf_en  (ctl.buf_en),
        .upd_evt (upd_evt),
        .psc_reg (psc_reg),
        .psc_act (psc_act),
        .rld_reg (rld_reg),
        .rld_act (rld_act)
    );

    evt_tmr_count #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl.run),
        .force_upd (dec.force_upd),
        .psc_act   (psc_act),
        .rld_act   (rld_act),
        .ovf_evt   (ovf_evt)
    );

    generate
        if (RLD_PAD > 0) begin : g_rld_pad
            assign rld_view = {{RLD_PAD{1'b0}}, rld_reg};
        end else begin : g_rld_full
            assign rld_view = rld_reg;
        end
        if (PSC_PAD > 0) begin : g_psc_pad
            assign psc_view = {{PSC_PAD{1'b0}}, psc_reg};
        end else begin : g_psc_full
            assign psc_view = psc_reg;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:   bus_rdata = pack_ctl(ctl);
            OFS_IEN:    bus_rdata[0] = ien;
            OFS_STAT:   bus_rdata[0] = flag;
            OFS_PSC:    bus_rdata = psc_view;
            OFS_RELOAD: bus_rdata = rld_view;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = flag & ien;

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(upd_evt) || $past(dec.ien_wr))) else $error("irq rose without cause"); // R9

endmodule

// File: tb/evt_tmr_test.sv
module evt_tmr_test;

    localparam int CNT_W = 16;
    localparam longint CMASK = (64'd1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R1";

    // reference model state
    longint m_cen, m_opm, m_arpe, m_uie, m_uif;
    longint m_psc_reg, m_psc_act, m_arr_reg, m_arr_act, m_cnt, m_pcnt;

    evt_tmr #(.CNT_W(CNT_W), .PSC_W(16)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_cen = 0; m_opm = 0; m_arpe = 0; m_uie = 0; m_uif = 0;
        m_psc_reg = 0; m_psc_act = 0; m_arr_reg = 0; m_arr_act = 0;
        m_cnt = 0; m_pcnt = 0;
    endtask

    function automatic longint model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_cen | (m_opm << 3) | (m_arpe << 7);
            8'h0C: return m_uie;
            8'h10: return m_uif;
            8'h28: return m_psc_reg;
            8'h2C: return m_arr_reg;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(input logic [7:0] a, input logic we, input logic [31:0] d);
        longint sw, pend, ovf, upd;
        longint n_cen, n_opm, n_arpe, n_uie, n_uif, n_psc_reg, n_psc_act;
        longint n_arr_reg, n_arr_act, n_cnt, n_pcnt;
        sw   = (we && a == 8'h14 && d[0]) ? 1 : 0;
        pend = (m_cen != 0 && m_pcnt == m_psc_act) ? 1 : 0;
        ovf  = (pend != 0 && m_cnt == m_arr_act) ? 1 : 0;
        upd  = (sw != 0 || ovf != 0) ? 1 : 0;
        n_cen = m_cen; n_opm = m_opm; n_arpe = m_arpe; n_uie = m_uie; n_uif = m_uif;
        n_psc_reg = m_psc_reg; n_psc_act = m_psc_act; n_arr_reg = m_arr_reg;
        n_arr_act = m_arr_act; n_cnt = m_cnt; n_pcnt = m_pcnt;
        if (sw != 0) begin
            n_cnt = 0; n_pcnt = 0;
        end else if (m_cen != 0) begin
            n_pcnt = (pend != 0) ? 0 : m_pcnt + 1;
            if (pend != 0) n_cnt = (ovf != 0) ? 0 : ((m_cnt + 1) & CMASK);
        end
        if (upd != 0) n_psc_act = m_psc_reg;
        if (we && a == 8'h28) n_psc_reg = d & 32'hFFFF;
        if (we && a == 8'h2C) n_arr_reg = d & CMASK;
        if (we && a == 8'h2C && m_arpe == 0) n_arr_act = d & CMASK;
        else if (upd != 0 && m_arpe != 0) n_arr_act = m_arr_reg;
        if (we && a == 8'h00) begin
            n_cen = d[0]; n_opm = d[3]; n_arpe = d[7];
        end else if (upd != 0 && m_opm != 0) begin
            n_cen = 0;
        end
        if (we && a == 8'h0C) n_uie = d[0];
        if (upd != 0) n_uif = 1;
        else if (we && a == 8'h10) n_uif = m_uif & d[0];
        m_cen = n_cen; m_opm = n_opm; m_arpe = n_arpe; m_uie = n_uie; m_uif = n_uif;
        m_psc_reg = n_psc_reg; m_psc_act = n_psc_act; m_arr_reg = n_arr_reg;
        m_arr_act = n_arr_act; m_cnt = n_cnt; m_pcnt = n_pcnt;
    endtask

    // one clock: drive, step model at the edge, compare 2 ns later
    task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d);
        bus_addr = a; bus_we = we; bus_wdata = d;
        @(posedge clk);
        model_step(a, we, d);
        #2;
        chk({cur_req, " model irq"}, irq, m_uif & m_uie);
        chk({cur_req, " model rdata"}, bus_rdata, model_read(a));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(a, 1'b1, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            case (i % 4)
                0: step(8'h10, 1'b0, 32'h0);
                1: step(8'h00, 1'b0, 32'h0);
                2: step(8'h2C, 1'b0, 32'h0);
                default: step(8'h28, 1'b0, 32'h0);
            endcase
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input longint exp);
        step(a, 1'b0, 32'h0);
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_flag(output int n);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            step(8'h10, 1'b0, 32'h0);
            n++;
            if (bus_rdata[0]) break;
        end
    endtask

    initial begin
        int n;
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        rd_chk("R1 ctrl", 8'h00, 0);
        rd_chk("R1 ien", 8'h0C, 0);
        rd_chk("R1 stat", 8'h10, 0);
        rd_chk("R1 psc", 8'h28, 0);
        rd_chk("R1 reload", 8'h2C, 0);
        chk("R1 irq", irq, 0);

        // R2: width discovery
        cur_req = "R2";
        wr(8'h2C, 32'hFFFF_FFFF);
        rd_chk("R2 reload readback", 8'h2C, 32'h0000_FFFF);

        // R10: unlisted bits and offsets
        cur_req = "R10";
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R10 undecoded offset", 8'h04, 0);
        rd_chk("R10 event-gen reads zero", 8'h14, 0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R10 ctrl masked", 8'h00, 32'h89);
        wr(8'h00, 32'h0);

        // R4: periodic, prescaler 0, reload 4
        cur_req = "R4";
        wr(8'h28, 0);
        wr(8'h2C, 4);
        wr(8'h14, 1);
        wr(8'h10, 0);
        wr(8'h00, 32'h1);
        wait_flag(n);
        chk("R4 first period", n, 5);
        idle(23);
        rd_chk("R4 still running", 8'h00, 1);

        // R3: prescaler of 2 held until update
        cur_req = "R3";
        wr(8'h00, 0);
        wr(8'h28, 2);
        wr(8'h2C, 1);
        wr(8'h14, 1);
        wr(8'h10, 0);
        wr(8'h00, 32'h1);
        wait_flag(n);
        chk("R3 divided period", n, 6);
        wr(8'h28, 0);
        idle(20);

        // R8: flag write semantics
        cur_req = "R8";
        wr(8'h00, 0);
        wr(8'h14, 1);
        wr(8'h10, 32'h1);
        rd_chk("R8 write one keeps flag", 8'h10, 1);
        wr(8'h10, 32'h0);
        rd_chk("R8 write zero clears", 8'h10, 0);

        // R7: forced update while stopped
        cur_req = "R7";
        wr(8'h14, 32'h2);
        rd_chk("R7 bit1 alone ignored", 8'h10, 0);
        wr(8'h14, 1);
        rd_chk("R7 forced flag", 8'h10, 1);

        // R9: interrupt gating
        cur_req = "R9";
        wr(8'h0C, 1);
        chk("R9 irq with enable", irq, 1);
        wr(8'h0C, 0);
        chk("R9 irq masked", irq, 0);
        wr(8'h0C, 1);
        wr(8'h10, 0);
        chk("R9 irq after clear", irq, 0);

        // R5: one-pulse
        cur_req = "R5";
        wr(8'h2C, 2);
        wr(8'h14, 1);
        wr(8'h10, 0);
        wr(8'h00, 32'h9);
        idle(12);
        rd_chk("R5 run cleared", 8'h00, 32'h8);
        rd_chk("R5 flag set once", 8'h10, 1);

        // R6: buffered and direct reload
        cur_req = "R6";
        wr(8'h00, 32'h80);
        wr(8'h2C, 3);
        wr(8'h14, 1);
        wr(8'h10, 0);
        wr(8'h2C, 9);
        wr(8'h00, 32'h81);
        wait_flag(n);
        chk("R6 old reload until update", n, 4);
        wr(8'h10, 0);
        wait_flag(n);
        chk("R6 new reload after update", n, 9);
        wr(8'h00, 32'h01);
        wr(8'h2C, 2);
        idle(30);
        wr(8'h2C, 6);
        idle(30);

        wr(8'h00, 0);
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule